// File: doc/BRIEF.md
# Atomic Word Memory Target

This block is a memory-side target that serves single-word atomic operations on a small internal array of 32-bit words. A requester sends command flits that carry an operation code, a word index and operand data. The block answers with response flits. Besides plain reads and writes it supports Linked Load (LL), Store Conditional (SC) and Compare-and-Swap (CAS). A lock-free update loop therefore runs against it without any lock held in the memory.

Each LL records a reservation that pairs the word index with a fresh signature and returns that signature to the requester. A later SC must present the same signature for the same word, and the reservation must still be live. Any store or plain read that reaches the word ends every reservation on it. CAS needs no reservation: it writes only when the expected old value equals the memory word.

A five-state controller sequences every operation:
- ST_IDLE: accepts the first flit. It goes to ST_ARG2 for SC or CAS, and to ST_EXEC for any other opcode.
- ST_ARG2: accepts the second flit and goes to ST_EXEC.
- ST_EXEC: reads the word, updates memory and reservations, and forms the result. It always goes to ST_RSP_HEAD.
- ST_RSP_HEAD: presents the first response flit. When it is taken, the controller goes to ST_RSP_TAIL after an LL, or back to ST_IDLE otherwise.
- ST_RSP_TAIL: presents the LL signature and returns to ST_IDLE when it is taken.

Top module: `atom_mem_target`

## Requirements
- R1: After reset, cmd_ready is 1, rsp_valid is 0, every word reads 0, no reservation is live (an SC without a prior LL fails), and the signature counter is 0.
- R2: Opcodes on cmd_op are 0 READ, 1 WRITE, 2 LL, 3 SC, 4 CAS. A READ takes one command flit and returns one response flit holding the word at cmd_widx, with rsp_eop set.
- R3: A WRITE takes one flit, stores cmd_wdata at cmd_widx, and returns one flit of value 0 with rsp_eop set.
- R4: An LL takes one flit and returns two flits: first the word with rsp_eop 0, then the signature with rsp_eop 1.
- R5: The signature returned by an LL equals the number of LLs served since reset, so it is 0 for the first LL and rises by 1 for each LL after it.
- R6: An SC carries the new value in its first flit and the signature in its second. If a live reservation matches both the word index and the signature, the SC stores the value and returns 0. Otherwise it returns 1 and leaves memory unchanged.
- R7: A successful SC, a WRITE or a READ at a word ends every reservation on that word. Reservations on other words stay live.
- R8: A CAS carries the expected old value in its first flit and the new value in its second. It stores the new value and returns 0 only when the word equals the old value. Otherwise it returns 1 with memory unchanged. Every SC or CAS response is a single flit with rsp_eop 1.
- R9: A successful CAS ends every reservation on its word. A failed CAS leaves them live.
- R10: The reservation table holds 4 entries filled round-robin starting from entry 0. Each LL takes the next entry, so the fifth live LL overwrites the oldest one.
- R11: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_data and rsp_eop hold, and cmd_ready stays 0.
- R12: Opcodes 5 to 7 take one flit, return a single flit of value 1, and change neither memory nor reservations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command flit present |
| cmd_ready | output | 1 | Block accepts a command flit this cycle |
| cmd_op | input | 3 | Operation code, held during every flit of a command |
| cmd_widx | input | 4 | Word index in the internal memory |
| cmd_wdata | input | 32 | Flit operand: write data, SC value or signature, CAS old or new value |
| rsp_valid | output | 1 | Response flit present |
| rsp_ready | input | 1 | Requester takes the response flit |
| rsp_data | output | 32 | Response payload: word, signature, or status (0 success, 1 failure) |
| rsp_eop | output | 1 | Marks the last flit of a response |

## Verification
A vector walk mixes writes, reads, LLs, SCs and CASes on several words, so each result depends on memory contents and on reservation state left by earlier operations. The SC cases tell apart a live match, a signature on the wrong word, a reservation cleared by a store, a CAS or a read, and an entry evicted by round-robin reuse. The CAS cases separate a matching expected value from a stale one, and show whether each outcome clears reservations. A stalled response checks that the two LL flits hold their value and their order under backpressure.

// File: rtl/atom_pkg.sv
package atom_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_LL    = 3'd2,
        OP_SC    = 3'd3,
        OP_CAS   = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARG2,
        ST_EXEC,
        ST_RSP_HEAD,
        ST_RSP_TAIL
    } state_e;

endpackage

// File: rtl/atom_word_mem.sv
module atom_word_mem #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata = mem_q[idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(idx)] == $past(wdata)); // R3

endmodule

// File: rtl/atom_resv_table.sv
module atom_resv_table #(
    parameter int IW      = 4,
    parameter int SW      = 32,
    parameter int ENTRIES = 4,
    localparam int PW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] op_idx,
    input  logic          alloc_en,
    output logic [SW-1:0] alloc_sig,
    input  logic [SW-1:0] chk_sig,
    output logic          chk_hit,
    input  logic          clr_en
);

    logic [ENTRIES-1:0] live_q;
    logic [IW-1:0]      eidx_q [ENTRIES];
    logic [SW-1:0]      esig_q [ENTRIES];
    logic [PW-1:0]      rr_q;
    logic [SW-1:0]      sig_q;
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] on_word;

    // Signature counter and round-robin pointer advance once per LL.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
            rr_q  <= '0;
        end else if (alloc_en) begin
            sig_q <= sig_q + 1'b1;
            rr_q  <= (rr_q == PW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        assign on_word[i] = live_q[i] && (eidx_q[i] == op_idx);
        assign hit_vec[i] = on_word[i] && (esig_q[i] == chk_sig);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_q[i] <= 1'b0;
                eidx_q[i] <= '0;
                esig_q[i] <= '0;
            end else if (alloc_en && rr_q == PW'(i)) begin
                live_q[i] <= 1'b1;
                eidx_q[i] <= op_idx;
                esig_q[i] <= sig_q;
            end else if (clr_en && on_word[i]) begin
                live_q[i] <= 1'b0;
            end
        end
    end

    assign alloc_sig = sig_q;
    assign chk_hit   = |hit_vec;

    AST_SIG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> sig_q == $past(sig_q) + 1'b1); // R5
    AST_SIG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R5
    AST_ALLOC_CLR_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_en && clr_en)); // R7
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (on_word == '0) || !$stable(op_idx)); // R7

endmodule

// File: rtl/atom_mem_target.sv
module atom_mem_target #(
    parameter int DW      = 32,
    parameter int DEPTH   = 16,
    parameter int RESV    = 4,
    localparam int IW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [IW-1:0] cmd_widx,
    input  logic [DW-1:0] cmd_wdata,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_eop
);
    import atom_pkg::*;

    localparam logic [DW-1:0] RES_OK   = '0;
    localparam logic [DW-1:0] RES_FAIL = DW'(1);

    state_e        state_q, state_d;
    op_e           op_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] opa_q, opb_q, d0_q, d1_q;
    logic          two_q;

    logic          cmd_fire;
    logic          ex_we, ex_clr, ex_alloc, chk_hit;
    logic [DW-1:0] ex_wdata, ex_res, mem_rdata, alloc_sig;

    atom_word_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ex_we),
        .idx   (idx_q),
        .wdata (ex_wdata),
        .rdata (mem_rdata)
    );

    atom_resv_table #(.IW(IW), .SW(DW), .ENTRIES(RESV)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_idx    (idx_q),
        .alloc_en  (ex_alloc),
        .alloc_sig (alloc_sig),
        .chk_sig   (opb_q),
        .chk_hit   (chk_hit),
        .clr_en    (ex_clr)
    );

    assign cmd_fire = cmd_valid && cmd_ready;

    // Execute-stage datapath: active only in ST_EXEC.
    always_comb begin
        ex_we    = 1'b0;
        ex_wdata = opa_q;
        ex_clr   = 1'b0;
        ex_alloc = 1'b0;
        ex_res   = RES_FAIL;
        if (state_q == ST_EXEC) begin
            case (op_q)
                OP_READ: begin
                    ex_res = mem_rdata;
                    ex_clr = 1'b1;
                end
                OP_WRITE: begin
                    ex_we  = 1'b1;
                    ex_clr = 1'b1;
                    ex_res = RES_OK;
                end
                OP_LL: begin
                    ex_alloc = 1'b1;
                    ex_res   = mem_rdata;
                end
                OP_SC: begin
                    if (chk_hit) begin
                        ex_we  = 1'b1;
                        ex_clr = 1'b1;
                        ex_res = RES_OK;
                    end
                end
                OP_CAS: begin
                    ex_wdata = opb_q;
                    if (mem_rdata == opa_q) begin
                        ex_we  = 1'b1;
                        ex_clr = 1'b1;
                        ex_res = RES_OK;
                    end
                end
                default: ex_res = RES_FAIL;
            endcase
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (cmd_fire)
                    state_d = (cmd_op == OP_SC || cmd_op == OP_CAS) ? ST_ARG2 : ST_EXEC;
            ST_ARG2:
                if (cmd_fire) state_d = ST_EXEC;
            ST_EXEC:
                state_d = ST_RSP_HEAD;
            ST_RSP_HEAD:
                if (rsp_ready) state_d = two_q ? ST_RSP_TAIL : ST_IDLE;
            ST_RSP_TAIL:
                if (rsp_ready) state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Operand and result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_READ;
            idx_q <= '0;
            opa_q <= '0;
            opb_q <= '0;
            d0_q  <= '0;
            d1_q  <= '0;
            two_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && cmd_fire) begin
                op_q  <= op_e'(cmd_op);
                idx_q <= cmd_widx;
                opa_q <= cmd_wdata;
            end
            if (state_q == ST_ARG2 && cmd_fire) opb_q <= cmd_wdata;
            if (state_q == ST_EXEC) begin
                d0_q  <= ex_res;
                d1_q  <= alloc_sig;
                two_q <= (op_q == OP_LL);
            end
        end
    end

    // Outputs.
    always_comb begin
        cmd_ready = (state_q == ST_IDLE) || (state_q == ST_ARG2);
        rsp_valid = (state_q == ST_RSP_HEAD) || (state_q == ST_RSP_TAIL);
        rsp_data  = (state_q == ST_RSP_TAIL) ? d1_q : d0_q;
        rsp_eop   = (state_q == ST_RSP_TAIL) || (state_q == ST_RSP_HEAD && !two_q);
    end

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_eop)); // R11
    AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready); // R11
    AST_LL_TWO_FLITS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && !rsp_eop |=> rsp_valid && rsp_eop); // R4
    AST_SC_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_EXEC && op_q == OP_SC && !chk_hit |-> !ex_we); // R6

endmodule

// File: tb/sim_atom_mem_target.sv
`timescale 1ns/1ps
module sim_atom_mem_target;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [3:0]  idx;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] x0;
        logic [31:0] x1;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  3'd1, 4'd1, 32'h1111_0000, 32'h0, 32'h0,          32'h0}, // R3 write
        '{4'd2,  3'd0, 4'd1, 32'h0,         32'h0, 32'h1111_0000,  32'h0}, // R2 read
        '{4'd4,  3'd2, 4'd1, 32'h0,         32'h0, 32'h1111_0000,  32'h0}, // R4 LL, sig 0 (R5)
        '{4'd6,  3'd3, 4'd1, 32'hAAAA_0001, 32'h0, 32'h0,          32'h0}, // R6 SC hit
        '{4'd6,  3'd0, 4'd1, 32'h0,         32'h0, 32'hAAAA_0001,  32'h0}, // R6 value stored
        '{4'd7,  3'd3, 4'd1, 32'h0000_BBBB, 32'h0, 32'h1,          32'h0}, // R7 SC after SC fails
        '{4'd6,  3'd0, 4'd1, 32'h0,         32'h0, 32'hAAAA_0001,  32'h0}, // R6 failed SC left memory
        '{4'd8,  3'd4, 4'd2, 32'h0,         32'h55, 32'h0,         32'h0}, // R8 CAS match
        '{4'd8,  3'd4, 4'd2, 32'h0,         32'h66, 32'h1,         32'h0}, // R8 CAS stale
        '{4'd8,  3'd0, 4'd2, 32'h0,         32'h0, 32'h55,         32'h0}, // R8 memory
        '{4'd5,  3'd2, 4'd3, 32'h0,         32'h0, 32'h0,          32'h1}, // R5 sig 1
        '{4'd5,  3'd2, 4'd4, 32'h0,         32'h0, 32'h0,          32'h2}, // R5 sig 2
        '{4'd3,  3'd1, 4'd3, 32'h77,        32'h0, 32'h0,          32'h0}, // R3 write clears
        '{4'd7,  3'd3, 4'd3, 32'h99,        32'h1, 32'h1,          32'h0}, // R7 cleared by write
        '{4'd7,  3'd3, 4'd4, 32'h12,        32'h2, 32'h0,          32'h0}, // R7 other word survives
        '{4'd12, 3'd5, 4'd4, 32'hFFFF,      32'h0, 32'h1,          32'h0}, // R12 bad opcode
        '{4'd12, 3'd0, 4'd4, 32'h0,         32'h0, 32'h12,         32'h0}  // R12 no effect
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [3:0]  cmd_widx = '0;
    logic [31:0] cmd_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_data;
    logic        rsp_eop;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    atom_mem_target u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_widx  (cmd_widx),
        .cmd_wdata (cmd_wdata),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data),
        .rsp_eop   (rsp_eop)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [2:0] op, input logic [3:0] idx,
                            input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_widx  = idx;
        cmd_wdata = a;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        if (op == 3'd3 || op == 3'd4) begin
            @(negedge clk);
            cmd_wdata = b;
            while (!cmd_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic get_rsp(output logic [31:0] d, output logic e);
        while (!(rsp_valid && rsp_ready)) @(negedge clk);
        d = rsp_data;
        e = rsp_eop;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_op(input string tag, input logic [2:0] op, input logic [3:0] idx,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] x0, input logic [31:0] x1);
        logic [31:0] d;
        logic        e;
        send_cmd(op, idx, a, b);
        get_rsp(d, e);
        check(tag, d, x0);
        check(tag, 32'(e), (op == 3'd2) ? 32'h0 : 32'h1);
        if (op == 3'd2) begin
            get_rsp(d, e);
            check(tag, d, x1);
            check(tag, 32'(e), 32'h1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, hold;
        logic        e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cmd_ready", 32'(cmd_ready), 32'h1);
        check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
        do_op("R1 word zero", 3'd0, 4'd0, 32'h0, 32'h0, 32'h0, 32'h0);
        do_op("R1 no reservation", 3'd3, 4'd0, 32'h5, 32'h0, 32'h1, 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_op($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].op, VECS[i].idx,
                  VECS[i].a, VECS[i].b, VECS[i].x0, VECS[i].x1);
        end

        // R10 round-robin eviction: sigs 3..7 on words 8..12
        for (int k = 0; k < 5; k++) begin
            do_op("R10 fill", 3'd2, 4'(8 + k), 32'h0, 32'h0, 32'h0, 32'(3 + k));
        end
        do_op("R10 evicted entry", 3'd3, 4'd8,  32'hE8, 32'h3, 32'h1, 32'h0);
        do_op("R10 kept entry",    3'd3, 4'd9,  32'hE9, 32'h4, 32'h0, 32'h0);
        do_op("R6 wrong word",     3'd3, 4'd11, 32'hEB, 32'h5, 32'h1, 32'h0);
        do_op("R6 memory untouched", 3'd0, 4'd11, 32'h0, 32'h0, 32'h0, 32'h0);

        // R9 CAS success clears, failure keeps
        do_op("R9 LL", 3'd2, 4'd13, 32'h0, 32'h0, 32'h0, 32'h8);
        do_op("R9 CAS ok", 3'd4, 4'd13, 32'h0, 32'h1, 32'h0, 32'h0);
        do_op("R9 SC after CAS", 3'd3, 4'd13, 32'h2, 32'h8, 32'h1, 32'h0);
        do_op("R9 LL", 3'd2, 4'd14, 32'h0, 32'h0, 32'h0, 32'h9);
        do_op("R9 CAS fail", 3'd4, 4'd14, 32'h5, 32'h1, 32'h1, 32'h0);
        do_op("R9 SC survives failed CAS", 3'd3, 4'd14, 32'h42, 32'h9, 32'h0, 32'h0);
        do_op("R9 SC stored", 3'd0, 4'd14, 32'h0, 32'h0, 32'h42, 32'h0);

        // R7 read clears
        do_op("R7 LL", 3'd2, 4'd15, 32'h0, 32'h0, 32'h0, 32'hA);
        do_op("R7 read", 3'd0, 4'd15, 32'h0, 32'h0, 32'h0, 32'h0);
        do_op("R7 SC after read", 3'd3, 4'd15, 32'h3, 32'hA, 32'h1, 32'h0);

        // R11 backpressure on a two-flit LL response
        rsp_ready = 1'b0;
        send_cmd(3'd2, 4'd2, 32'h0, 32'h0);
        while (!rsp_valid) @(negedge clk);
        hold = rsp_data;
        check("R11 head data", hold, 32'h55);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R11 valid held", 32'(rsp_valid), 32'h1);
            check("R11 data held", rsp_data, hold);
            check("R11 eop held", 32'(rsp_eop), 32'h0);
            check("R11 no cmd", 32'(cmd_ready), 32'h0);
        end
        rsp_ready = 1'b1;
        get_rsp(d, e);
        check("R4 head", d, 32'h55);
        check("R4 head eop", 32'(e), 32'h0);
        get_rsp(d, e);
        check("R5 tail sig", d, 32'hB);
        check("R4 tail eop", 32'(e), 32'h1);
        @(negedge clk);
        check("R11 idle again", 32'(cmd_ready), 32'h1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule